// File: doc/BRIEF.md
# Indirect Extended Register Window

This unit sits on the internal register bus, behind whatever host protocol engine decodes serial or parallel transfers into simple register accesses. It opens a window onto a second bank of 64 six-bit extended registers through one primary register location, 0x0F. No flat address space is spent on the bank. Each byte written to the window carries a two-bit command in its upper bits and a six-bit operand in its lower bits.

The command selects one of three actions: load the write pointer, load the read pointer, or store the operand into the extended register that the write pointer selects. Code 00 is reserved for data flowing back to the host, so a write that carries it does nothing. A read of the window returns the register that the read pointer selects, with 00 in the two command bits.

The two pointers hold their values until they are reloaded, so a pointer set once serves any number of data transfers. The whole bank is also presented as a flat vector for the neighbouring logic that the extended registers control.

Top module: `ext_reg_window`

## Requirements
- R1: After a synchronous active-low reset, both pointers are 0 and every extended register is 0. A read of 0x0F then returns 0x00.
- R2: A write to 0x0F whose bits 7..6 are 01 loads bits 5..0 into the write pointer.
- R3: A write to 0x0F whose bits 7..6 are 10 loads bits 5..0 into the read pointer.
- R4: A write to 0x0F whose bits 7..6 are 11 stores bits 5..0 into the extended register at the write pointer. No other extended register changes.
- R5: While the bus address is 0x0F, bus_rdata is combinationally {2'b00, ext[read pointer]}. Its bits 7..6 are always 0.
- R6: A write to 0x0F whose bits 7..6 are 00 changes neither pointer nor any extended register.
- R7: A write to any address other than 0x0F changes neither pointer nor any extended register.
- R8: Loading one pointer leaves the other pointer unchanged.
- R9: While the bus address is not 0x0F, bus_rdata is 0x00.
- R10: Pointers never advance by themselves. Consecutive data writes all target the same extended register.
- R11: ext_regs_o carries extended register k in bits [6k+5:6k], and it is updated on the same clock edge as the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register bus address |
| bus_wdata | input | 8 | Write data: command in bits 7..6, operand in bits 5..0 |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_regs_o | output | 384 | Flat view of all 64 extended registers |

## Verification
The pointers cannot be seen at the ports. An ignored write (R6, R7) or a pointer held while the other is reloaded (R8) therefore only shows up through a later data store or a later read. The bench first gives every register a distinct value through a full sweep. After that, any write that went to the wrong register, or any pointer that moved, leaves a visible mismatch. It then issues each suspicious write and at once reads back through the unchanged read pointer and the flat register view. A second sweep with a different value pattern checks that every location can be overwritten.

// File: rtl/ext_reg_window_pkg.sv
// Package: shared command encoding for the indirect extended register window.
// Assumes the command sits in the two most significant bits of every window byte.
package ext_reg_window_pkg;

    typedef enum logic [1:0] {
        CMD_RETURN   = 2'b00,
        CMD_SET_WPTR = 2'b01,
        CMD_SET_RPTR = 2'b10,
        CMD_STORE    = 2'b11
    } win_cmd_e;

endpackage

// File: rtl/ext_reg_window_decode.sv
// Module: ext_reg_window_decode
// Turns one bus write into at most one action strobe: load write pointer,
// load read pointer, or store. Assumes the bus address and strobe are valid
// for the cycle in which the strobe is high. Purely combinational.
module ext_reg_window_decode
    import ext_reg_window_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter logic [ADDR_W-1:0] WINDOW_ADDR = 6'h0F
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              hit,
    output logic              ld_wptr,
    output logic              ld_rptr,
    output logic              store
);

    win_cmd_e cmd;

    // Classify the command field and gate it with an addressed write.
    always_comb begin
        cmd     = win_cmd_e'(bus_wdata[DATA_W-1 -: 2]);
        hit     = (bus_addr == WINDOW_ADDR);
        ld_wptr = 1'b0;
        ld_rptr = 1'b0;
        store   = 1'b0;
        if (hit && bus_we) begin
            unique case (cmd)
                CMD_SET_WPTR: ld_wptr = 1'b1;
                CMD_SET_RPTR: ld_rptr = 1'b1;
                CMD_STORE:    store   = 1'b1;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/ext_reg_window_ptr.sv
// Module: ext_reg_window_ptr
// A pointer register that loads only on its strobe and otherwise holds.
// Assumes a synchronous active-low reset that clears it to zero.
module ext_reg_window_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] din,
    output logic [PTR_W-1:0] q
);

    // Hold or reload the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end

endmodule

// File: rtl/ext_reg_window_bank.sv
// Module: ext_reg_window_bank
// The bank of extended registers. A store writes one entry, picked by the
// write pointer. Assumes at most one store per clock. Cleared by reset.
module ext_reg_window_bank #(
    parameter int PTR_W   = 6,
    parameter int FIELD_W = 6,
    localparam int NUM_REGS = 1 << PTR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              store,
    input  logic [PTR_W-1:0]                  wsel,
    input  logic [FIELD_W-1:0]                wval,
    output logic [NUM_REGS-1:0][FIELD_W-1:0]  regs
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
        // Each entry captures the operand when it is the store target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (store && (wsel == PTR_W'(k)))
                regs[k] <= wval;
        end
    end

endmodule

// File: rtl/ext_reg_window.sv
// Module: ext_reg_window (top)
// Indirect window from one primary bus register onto a bank of extended
// registers. It has separate write and read pointers. Assumes a
// single-cycle write strobe on the register bus and a combinational read path.
module ext_reg_window #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter logic [ADDR_W-1:0] WINDOW_ADDR = 6'h0F,
    localparam int FIELD_W  = DATA_W - 2,
    localparam int PTR_W    = FIELD_W,
    localparam int NUM_REGS = 1 << PTR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic                         bus_we,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_REGS*FIELD_W-1:0]  ext_regs_o
);

    logic                             hit;
    logic                             ld_wptr;
    logic                             ld_rptr;
    logic                             store;
    logic [PTR_W-1:0]                 wr_ptr;
    logic [PTR_W-1:0]                 rd_ptr;
    logic [NUM_REGS-1:0][FIELD_W-1:0] regs;

    ext_reg_window_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW_ADDR(WINDOW_ADDR)
    ) u_decode (
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .hit(hit), .ld_wptr(ld_wptr), .ld_rptr(ld_rptr), .store(store)
    );

    ext_reg_window_ptr #(.PTR_W(PTR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .load(ld_wptr),
        .din(bus_wdata[PTR_W-1:0]), .q(wr_ptr)
    );

    ext_reg_window_ptr #(.PTR_W(PTR_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .load(ld_rptr),
        .din(bus_wdata[PTR_W-1:0]), .q(rd_ptr)
    );

    ext_reg_window_bank #(.PTR_W(PTR_W), .FIELD_W(FIELD_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .store(store),
        .wsel(wr_ptr), .wval(bus_wdata[FIELD_W-1:0]), .regs(regs)
    );

    // Return the selected entry with a zero command field, or zero off-window.
    always_comb begin
        if (hit)
            bus_rdata = {2'b00, regs[rd_ptr]};
        else
            bus_rdata = '0;
    end

    // Expose the bank to neighbouring logic.
    assign ext_regs_o = regs;

endmodule

// File: rtl/ext_reg_window_chk.sv
// Module: ext_reg_window_chk
// Property checker for ext_reg_window, attached by bind. It observes the
// ports and the two internal pointers.
module ext_reg_window_chk #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 8,
    parameter int PTR_W   = 6,
    parameter int FIELD_W = 6,
    parameter int NUM_REGS = 64,
    parameter logic [ADDR_W-1:0] WINDOW_ADDR = 6'h0F
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic                         bus_we,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_REGS*FIELD_W-1:0]  ext_regs_o,
    input logic [PTR_W-1:0]             wr_ptr,
    input logic [PTR_W-1:0]             rd_ptr
);

    logic             on_win;
    logic [1:0]       cmd;
    logic [FIELD_W-1:0] at_wptr;

    // Helper views used by the properties.
    always_comb begin
        on_win  = (bus_addr == WINDOW_ADDR);
        cmd     = bus_wdata[DATA_W-1 -: 2];
        at_wptr = ext_regs_o[wr_ptr*FIELD_W +: FIELD_W];
    end

    p_wptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b01) |=> (wr_ptr == $past(bus_wdata[PTR_W-1:0])));

    p_rptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b10) |=> (rd_ptr == $past(bus_wdata[PTR_W-1:0])));

    p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b11) |=> (at_wptr == $past(bus_wdata[FIELD_W-1:0])));

    p_rdata_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        on_win |-> (bus_rdata[DATA_W-1 -: 2] == 2'b00));

    p_ignore_cmd00_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b00) |=>
            ($stable(wr_ptr) && $stable(rd_ptr) && $stable(ext_regs_o)));

    p_ignore_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_win && bus_we) |=>
            ($stable(wr_ptr) && $stable(rd_ptr) && $stable(ext_regs_o)));

    p_wptr_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b10) |=> $stable(wr_ptr));

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_win) |-> (bus_rdata == '0));

    p_no_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (on_win && bus_we && cmd == 2'b11) |=> $stable(wr_ptr) && $stable(rd_ptr));

endmodule

bind ext_reg_window ext_reg_window_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .FIELD_W(FIELD_W),
    .NUM_REGS(NUM_REGS), .WINDOW_ADDR(WINDOW_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ext_regs_o(ext_regs_o),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_ext_reg_window.sv
// Testbench for ext_reg_window. It sweeps all extended registers with two
// value patterns, which it computes itself, and then probes the corner cases.
module test_ext_reg_window;

    localparam logic [5:0] WIN = 6'h0F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_rdata;
    logic [383:0] ext_regs_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    ext_reg_window i_ext_reg_window (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ext_regs_o(ext_regs_o)
    );

    // Expected value for register i under pattern p.
    function automatic logic [5:0] pat(int i, int p);
        return 6'((i * (p == 0 ? 37 : 11) + (p == 0 ? 5 : 50)) % 64);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One bus write: drive at negedge, captured at the next posedge.
    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = WIN;
    endtask

    // Read through the window with the read pointer set to i.
    task automatic rd_at(logic [5:0] i, output logic [7:0] v);
        wr(WIN, {2'b10, i});
        bus_addr = WIN;
        #1 v = bus_rdata;
    endtask

    function automatic logic [5:0] flat(int i);
        return ext_regs_o[i*6 +: 6];
    endfunction

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = WIN;
        #1;
        chk("R1 reset read", bus_rdata, 8'h00);
        chk("R1 reset bank", {2'b00, flat(63)}, 8'h00);

        // First sweep: set the write pointer, then store pattern 0.
        for (int i = 0; i < 64; i++) begin
            wr(WIN, {2'b01, 6'(i)});
            wr(WIN, {2'b11, pat(i, 0)});
            chk("R11 flat view after store", {2'b00, flat(i)}, {2'b00, pat(i, 0)});
        end
        for (int i = 0; i < 64; i++) begin
            rd_at(6'(i), v);
            chk("R2 R3 R4 R5 sweep readback", v, {2'b00, pat(i, 0)});
        end

        // R9: off-window address reads as zero.
        bus_addr = 6'h0E; #1;
        chk("R9 off-window read", bus_rdata, 8'h00);
        bus_addr = 6'h10; #1;
        chk("R9 off-window read", bus_rdata, 8'h00);

        // R8: read pointer 5, then reload the write pointer; the read stays on 5.
        rd_at(6'd5, v);
        wr(WIN, {2'b01, 6'd9});
        #1 chk("R8 read pointer kept", bus_rdata, {2'b00, pat(5, 0)});
        // R8: the write pointer stays 9 after a read pointer reload.
        wr(WIN, {2'b10, 6'd40});
        wr(WIN, {2'b11, 6'h2A});
        chk("R8 write pointer kept", {2'b00, flat(9)}, 8'h2A);
        chk("R8 neighbour intact", {2'b00, flat(40)}, {2'b00, pat(40, 0)});

        // R6: a write with command 00 must change nothing.
        rd_at(6'd20, v);
        wr(WIN, {2'b00, 6'd33});
        #1 chk("R6 read pointer unchanged", bus_rdata, {2'b00, pat(20, 0)});
        chk("R6 reg 9 unchanged", {2'b00, flat(9)}, 8'h2A);
        chk("R6 reg 33 unchanged", {2'b00, flat(33)}, {2'b00, pat(33, 0)});
        wr(WIN, {2'b11, 6'h15});
        chk("R6 write pointer unchanged", {2'b00, flat(9)}, 8'h15);

        // R7: writes of every command to another address change nothing.
        wr(6'h0E, {2'b01, 6'd50});
        wr(6'h0E, {2'b10, 6'd51});
        wr(6'h2F, {2'b11, 6'h3F});
        bus_addr = WIN; #1;
        chk("R7 read pointer unchanged", bus_rdata, {2'b00, pat(20, 0)});
        chk("R7 reg 9 unchanged", {2'b00, flat(9)}, 8'h15);
        chk("R7 reg 50 unchanged", {2'b00, flat(50)}, {2'b00, pat(50, 0)});

        // R10: consecutive stores hit the same register.
        wr(WIN, {2'b01, 6'd3});
        wr(WIN, {2'b11, 6'h11});
        wr(WIN, {2'b11, 6'h22});
        chk("R10 last store wins", {2'b00, flat(3)}, 8'h22);
        chk("R10 next reg untouched", {2'b00, flat(4)}, {2'b00, pat(4, 0)});

        // Second sweep with pattern 1, written in descending order.
        for (int i = 63; i >= 0; i--) begin
            wr(WIN, {2'b01, 6'(i)});
            wr(WIN, {2'b11, pat(i, 1)});
        end
        for (int i = 0; i < 64; i++) begin
            rd_at(6'(i), v);
            chk("R4 R5 second sweep", v, {2'b00, pat(i, 1)});
            chk("R11 second sweep flat", {2'b00, flat(i)}, {2'b00, pat(i, 1)});
        end

        // R1: reset clears the bank and both pointers again.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_addr = WIN; #1;
        chk("R1 reset read after use", bus_rdata, 8'h00);
        chk("R1 reset bank after use", {2'b00, flat(17)}, 8'h00);
        wr(WIN, {2'b11, 6'h07});
        #1 chk("R1 both pointers zero", bus_rdata, 8'h07);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule